// File: doc/BRIEF.md
# Framed Angle Pulse-Width Encoder

This block turns a shaft angle in the range 0 to 359 and an error flag into a pulse-width modulated line with a fixed frame length. Time inside a frame is counted in steps, and one step passes per step tick. Every frame begins with a fixed 12-step high marker. A 4-step offset follows. Then comes a high stretch that is one step longer per angle LSB. The frame ends with low steps and a low 8-step exit tail. A frame that carries an error flag keeps only the 12-step marker high, so a receiver can tell an error frame from a zero angle.

The step tick comes from one of two sources. The first is an internal enable that is qualified on the system clock. The second is an asynchronous external clock pin: its rising edges are synchronised into the system clock and turned into ticks. After reset the encoder stays idle with its output low. It starts its first frame only after four ticks of the selected source have been seen, so the start is tied to the chosen clock.

Top module: `angle_pwm_enc`

## Requirements
- R1: While reset is asserted, and afterwards until the start-up release, `pwm_out` is low.
- R2: Once running, a frame lasts exactly 383 steps, and `pwm_out` is high at the first step of every frame.
- R3: In a frame without error, `pwm_out` is high for 16 + A steps and low for the remaining 367 − A steps, where A is the angle sampled in the clock cycle in which the frame begins. Changing `angle_in` later in that frame does not alter it. The last 8 steps of every frame are low.
- R4: A sampled angle above 359 is treated as 359, which gives a high time of 375 steps.
- R5: The error flag is sampled only on the tick that moves from step 11 to step 12, counting steps from 0. If it is 1 there, that frame is high for exactly 12 steps. An error level present only at other steps has no effect.
- R6: The frame advances by exactly one step per tick. With no ticks, the step position and `pwm_out` hold.
- R7: After reset, the engine is released on the 4th tick of the selected source. The first frame starts in the following clock cycle.
- R8: With `ext_clk_sel` = 1, a tick is a rising edge of `ext_clk_pin` after a two-flop synchroniser. Each tick acts on the third system-clock edge after the pin level is first sampled high. `int_step_en` is ignored in this mode.
- R9: With `ext_clk_sel` = 0, a tick is `int_step_en` = 1 at a system-clock edge, and `ext_clk_pin` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_sel | input | 1 | Step source: 0 selects the internal enable, 1 selects the external pin |
| int_step_en | input | 1 | Internal step enable, one step per cycle in which it is high |
| ext_clk_pin | input | 1 | Asynchronous external step clock |
| angle_in | input | 9 | Angle code, 0..359 |
| err_in | input | 1 | Error flag for the current measurement |
| pwm_out | output | 1 | Framed pulse-width output |

## Verification
The assertions take for granted that `ext_clk_sel` stays constant between resets. They also assume that the external pin is slow compared with the system clock, with each high and each low level lasting at least two system clocks, so that no edge is lost in the synchroniser. The stimulus changes the source select only while reset is held. It toggles the pin with a four-cycle period, and it changes the angle and error inputs between clock edges. Pseudo-random activity on the unused source shows that this source is ignored.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
    localparam int unsigned DEF_ANGLE_W   = 9;
    localparam int unsigned DEF_ANGLE_MAX = 359;
    localparam int unsigned DEF_LEAD      = 12;
    localparam int unsigned DEF_OFFSET    = 4;
    localparam int unsigned DEF_EXIT      = 8;
    localparam int unsigned DEF_RELEASE   = 4;
    localparam int unsigned DEF_SYNC      = 2;

    typedef enum logic {
        SRC_INTERNAL = 1'b0,
        SRC_EXTERNAL = 1'b1
    } step_src_e;
endpackage

// File: rtl/apwm_edge_sync.sv
module apwm_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.sh = {s_q.sh[STAGES-1:0], pin};
        rise   = s_q.sh[STAGES-1] & ~s_q.sh[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8: a synchronised edge yields a single-cycle tick
    p_rise_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/apwm_release_gate.sv
module apwm_release_gate #(
    parameter int unsigned RELEASE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic run
);
    localparam int unsigned CNT_W = $clog2(RELEASE_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } gate_t;

    gate_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!g_q.run && tick) begin
            if (g_q.cnt == CNT_W'(RELEASE_TICKS - 1)) begin
                g_d.run = 1'b1;
                g_d.cnt = '0;
            end else begin
                g_d.cnt = g_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign run = g_q.run;

    // R7: once released the engine stays released until reset
    p_run_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        g_q.run |=> g_q.run);
    // R7: release only happens on a tick of the selected source
    p_release_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(g_q.run) |-> $past(tick));
endmodule

// File: rtl/apwm_frame.sv
module apwm_frame #(
    parameter int unsigned ANGLE_W   = 9,
    parameter int unsigned ANGLE_MAX = 359,
    parameter int unsigned LEAD      = 12,
    parameter int unsigned OFFSET    = 4,
    parameter int unsigned EXIT      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic [ANGLE_W-1:0] angle_in,
    input  logic               err_in,
    output logic               pwm
);
    localparam int unsigned BASE  = LEAD + OFFSET;
    localparam int unsigned FRAME = BASE + ANGLE_MAX + EXIT;
    localparam int unsigned POS_W = $clog2(FRAME);

    typedef struct packed {
        logic               started;
        logic [POS_W-1:0]   pos;
        logic [ANGLE_W-1:0] ang;
        logic               err_cut;
        logic               pwm;
    } frame_t;

    frame_t f_d, f_q;
    logic [ANGLE_W-1:0] ang_clamped;

    function automatic logic level_at(input logic [POS_W-1:0]   p,
                                      input logic [ANGLE_W-1:0] a,
                                      input logic               cut);
        int unsigned pi, ai;
        pi = int'(p);
        ai = int'(a);
        return (pi < LEAD) || (!cut && (pi < BASE + ai));
    endfunction

    always_comb begin
        ang_clamped = (angle_in > ANGLE_W'(ANGLE_MAX)) ? ANGLE_W'(ANGLE_MAX) : angle_in;
        f_d = f_q;
        if (!run) begin
            f_d = '0;
        end else if (!f_q.started) begin
            f_d.started = 1'b1;
            f_d.pos     = '0;
            f_d.ang     = ang_clamped;
            f_d.err_cut = 1'b0;
            f_d.pwm     = level_at('0, ang_clamped, 1'b0);
        end else if (tick) begin
            if (f_q.pos == POS_W'(FRAME - 1)) begin
                f_d.pos     = '0;
                f_d.ang     = ang_clamped;
                f_d.err_cut = 1'b0;
            end else begin
                f_d.pos = f_q.pos + 1'b1;
            end
            if (f_d.pos == POS_W'(LEAD)) f_d.err_cut = err_in;
            f_d.pwm = level_at(f_d.pos, f_d.ang, f_d.err_cut);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign pwm = f_q.pwm;

    // R2: the leading marker is always high
    p_lead_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.started && int'(f_q.pos) < LEAD) |-> f_q.pwm);
    // R2: wrap returns to step zero with the output high
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && f_q.started && tick && f_q.pos == POS_W'(FRAME - 1)) |=> (f_q.pos == '0 && f_q.pwm));
    // R3: the exit tail is low
    p_exit_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.started && int'(f_q.pos) >= FRAME - EXIT) |-> !f_q.pwm);
    // R4: the held angle never exceeds the top code
    p_angle_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        f_q.started |-> (int'(f_q.ang) <= ANGLE_MAX));
    // R5: an error frame is low after the marker
    p_err_short_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.started && f_q.err_cut && int'(f_q.pos) >= LEAD) |-> !f_q.pwm);
    // R6: no tick, no movement
    p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && f_q.started && !tick) |=> ($stable(f_q.pos) && $stable(f_q.pwm)));
endmodule

// File: rtl/angle_pwm_enc.sv
module angle_pwm_enc
    import apwm_pkg::*;
#(
    parameter int unsigned ANGLE_W       = DEF_ANGLE_W,
    parameter int unsigned ANGLE_MAX     = DEF_ANGLE_MAX,
    parameter int unsigned LEAD          = DEF_LEAD,
    parameter int unsigned OFFSET        = DEF_OFFSET,
    parameter int unsigned EXIT          = DEF_EXIT,
    parameter int unsigned RELEASE_TICKS = DEF_RELEASE,
    parameter int unsigned SYNC_STAGES   = DEF_SYNC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_clk_sel,
    input  logic               int_step_en,
    input  logic               ext_clk_pin,
    input  logic [ANGLE_W-1:0] angle_in,
    input  logic               err_in,
    output logic               pwm_out
);
    step_src_e src;
    logic      ext_rise;
    logic      tick;
    logic      run;

    assign src = step_src_e'(ext_clk_sel);

    apwm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_clk_pin),
        .rise  (ext_rise)
    );

    always_comb begin
        tick = (src == SRC_EXTERNAL) ? ext_rise : int_step_en;
    end

    apwm_release_gate #(.RELEASE_TICKS(RELEASE_TICKS)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .run   (run)
    );

    apwm_frame #(
        .ANGLE_W   (ANGLE_W),
        .ANGLE_MAX (ANGLE_MAX),
        .LEAD      (LEAD),
        .OFFSET    (OFFSET),
        .EXIT      (EXIT)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .angle_in (angle_in),
        .err_in   (err_in),
        .pwm      (pwm_out)
    );

    // R1: the output stays low until the engine is released
    p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);
endmodule

// File: tb/angle_pwm_enc_tb.sv
`timescale 1ns/1ps
module angle_pwm_enc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk_sel = 1'b0;
    logic       int_step_en = 1'b0;
    logic       ext_clk_pin = 1'b0;
    logic [8:0] angle_in = '0;
    logic       err_in = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int failures = 0;

    // stimulus modes: 0 always on, 1 alternate, 2 off, 3 pseudo-random
    int       en_mode = 0;
    bit       pin_on = 1'b0;
    int       pin_cnt = 0;
    bit [7:0] lfsr = 8'h5a;
    bit       alt = 1'b0;

    always #10 clk = ~clk;

    angle_pwm_enc u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_clk_sel (ext_clk_sel),
        .int_step_en (int_step_en),
        .ext_clk_pin (ext_clk_pin),
        .angle_in    (angle_in),
        .err_in      (err_in),
        .pwm_out     (pwm_out)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // background drivers for the two step sources
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        alt  = ~alt;
        case (en_mode)
            0:       int_step_en = 1'b1;
            1:       int_step_en = alt;
            2:       int_step_en = 1'b0;
            default: int_step_en = lfsr[0];
        endcase
        if (pin_on) begin
            pin_cnt++;
            if (pin_cnt == 2) begin
                pin_cnt = 0;
                ext_clk_pin = ~ext_clk_pin;
            end
        end
    end

    // behavioural reference, advanced at each clock edge
    bit    h1, h2, h3;
    bit    m_run, m_live, m_cut, m_pwm;
    int    m_cnt, m_pos, m_ang;
    string m_tag;

    always @(posedge clk) begin
        bit t;
        if (!rst_n) begin
            h1 = 0; h2 = 0; h3 = 0;
            m_run = 0; m_live = 0; m_cut = 0; m_pwm = 0;
            m_cnt = 0; m_pos = 0; m_ang = 0;
        end else begin
            t  = ext_clk_sel ? (h2 && !h3) : int_step_en;
            h3 = h2; h2 = h1; h1 = ext_clk_pin;
            if (!m_run) begin
                m_live = 0; m_pos = 0; m_pwm = 0;
            end else if (!m_live) begin
                m_live = 1; m_pos = 0; m_cut = 0;
                m_ang  = (angle_in > 359) ? 359 : int'(angle_in);
                m_pwm  = 1;
            end else if (t) begin
                m_pos = (m_pos + 1) % 383;
                if (m_pos == 0) begin
                    m_ang = (angle_in > 359) ? 359 : int'(angle_in);
                    m_cut = 0;
                end
                if (m_pos == 12) m_cut = err_in;
                m_pwm = (m_pos < 12) || (!m_cut && m_pos < 16 + m_ang);
            end
            if (!m_run && t) begin
                m_cnt++;
                if (m_cnt == 4) m_run = 1;
            end
        end
        m_tag = !m_run ? "R7" : (ext_clk_sel ? "R8" : (m_cut ? "R5" : "R3"));
    end

    // per-cycle comparison, away from the active edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n) chk(m_tag, int'(pwm_out), int'(m_pwm), "cycle compare with reference");
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic do_reset(input bit sel);
        @(negedge clk);
        rst_n = 1'b0;
        ext_clk_sel = sel;
        repeat (4) @(negedge clk);
        #1;
        chk("R1", int'(pwm_out), 0, "output during reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // measure one frame in clock cycles from a rising edge of the output
    task automatic measure(input int mid_at, input logic [8:0] mid_ang,
                           input int ef, input int et,
                           output int hi, output int per);
        bit last, found, got;
        int k;
        last = 1; found = 0;
        while (!found) begin
            @(negedge clk); #1;
            got = pwm_out;
            found = got && !last;
            last = got;
        end
        hi = 0; per = 0; k = 0;
        found = 0;
        while (!found) begin
            per++;
            if (pwm_out) hi++;
            err_in = (k >= ef && k <= et);
            if (k == mid_at) angle_in = mid_ang;
            last = pwm_out;
            @(negedge clk); #1;
            k++;
            found = pwm_out && !last;
        end
        err_in = 1'b0;
    endtask

    initial begin
        int hi, per, changes;
        bit ref_lvl;
        // internal source, external pin toggling as noise (R9)
        en_mode = 0; pin_on = 1; angle_in = 9'd0;
        do_reset(1'b0);
        // R7: released on the 4th tick, first frame in the next cycle
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk); #1;
            chk("R7", int'(pwm_out), (i == 5) ? 1 : 0, $sformatf("start-up cycle %0d", i));
        end
        measure(-1, 0, -1, -1, hi, per);
        chk("R3", hi, 16, "high steps at angle 0");
        chk("R2", per, 383, "frame length");
        chk("R9", per, 383, "pin activity ignored in internal mode");
        angle_in = 9'd100;
        measure(-1, 0, -1, -1, hi, per);
        chk("R3", hi, 116, "high steps at angle 100");
        angle_in = 9'd359;
        measure(-1, 0, -1, -1, hi, per);
        chk("R3", hi, 375, "high steps at angle 359");
        chk("R2", per, 383, "frame length at top angle");
        angle_in = 9'd500;
        measure(-1, 0, -1, -1, hi, per);
        chk("R4", hi, 375, "angle 500 clamped");
        angle_in = 9'd511;
        measure(-1, 0, -1, -1, hi, per);
        chk("R4", hi, 375, "angle 511 clamped");
        angle_in = 9'd40;
        measure(5, 9'd300, -1, -1, hi, per);
        chk("R3", hi, 56, "mid-frame angle change ignored");
        measure(-1, 0, -1, -1, hi, per);
        chk("R3", hi, 316, "new angle used next frame");
        angle_in = 9'd30;
        measure(-1, 0, -1, -1, hi, per);
        measure(-1, 0, 0, 20, hi, per);
        chk("R5", hi, 12, "error across step 11 shortens frame");
        chk("R5", per, 383, "error frame length");
        measure(-1, 0, 11, 11, hi, per);
        chk("R5", hi, 12, "error only at step 11");
        measure(-1, 0, 0, 10, hi, per);
        chk("R5", hi, 46, "error before sample point ignored");
        measure(-1, 0, 13, 382, hi, per);
        chk("R5", hi, 46, "error after sample point ignored");
        // R6: half-rate ticks stretch the frame, no ticks freeze it
        en_mode = 1;
        measure(-1, 0, -1, -1, hi, per);
        measure(-1, 0, -1, -1, hi, per);
        chk("R6", per, 766, "frame cycles at half tick rate");
        chk("R6", hi, 92, "high cycles at half tick rate");
        en_mode = 2;
        repeat (3) @(negedge clk);
        #1; ref_lvl = pwm_out; changes = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #1;
            if (pwm_out !== ref_lvl) changes++;
        end
        chk("R6", changes, 0, "output frozen without ticks");
        // external source, internal enable random as noise
        en_mode = 3; pin_on = 1;
        do_reset(1'b1);
        measure(-1, 0, -1, -1, hi, per);
        measure(-1, 0, -1, -1, hi, per);
        chk("R8", per, 1532, "frame cycles on external clock");
        chk("R8", hi, 184, "high cycles on external clock");
        pin_on = 0;
        repeat (4) @(negedge clk);
        #1; ref_lvl = pwm_out; changes = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk); #1;
            if (pwm_out !== ref_lvl) changes++;
        end
        chk("R8", changes, 0, "internal enable ignored in external mode");
        finish_run();
    end
endmodule